// File: doc/BRIEF.md
# Synchronous Nibble RAM

A small single-clock memory of sixteen 4-bit words. The address is binary, and a word's index equals its address value. Every clock edge does one of three operations, chosen by the read/write select and the write enable.

When the select is high and the enable is high, the addressed word is written. When the select is high and the enable is low, nothing happens. When the select is low, the addressed word is read, and the enable makes no difference.

The output is a register. A read shows the addressed word one edge later. A write passes the incoming data straight to the output on the same edge that stores it. The output therefore never shows the old content of a word that has just been overwritten.

Each word is an ordinary register. It loads through a hold/load multiplexer, and the clock is never gated. One active-low synchronous reset clears every word and the output.

Top module: `nram_core`

## Requirements
- R1: The memory holds 16 independent 4-bit words. The 4-bit `addr` selects word number `addr`, read as an unsigned binary value from 0 to 15.
- R2: At a rising edge where `rw`=1 and `en`=1, word `addr` takes the value of `din`.
- R3: At a rising edge where `rw`=1 and `en`=0, no word changes and `dout` keeps its previous value, whatever `din` and `addr` are.
- R4: At a rising edge where `rw`=0, `dout` takes the content of word `addr` and no word changes. This holds for both values of `en`.
- R5: At a write edge (R2), `dout` takes the `din` being written, so the new value is visible one clock after the write is presented.
- R6: At a rising edge where `rst_n`=0, every word and `dout` become 0000.
- R7: A write changes only the addressed word. For example, writing 1000 at address 0011 sets word 3 to 1000 and leaves words 2 and 4 as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | The single clock. Everything is updated on its rising edge. |
| rst_n | input | 1 | Synchronous reset, active low. Clears all words and the output. |
| addr | input | 4 | Word index, unsigned binary. |
| din | input | 4 | Data to be written. |
| rw | input | 1 | 1 selects a write (subject to `en`), 0 selects a read. |
| en | input | 1 | Write enable. It has no effect on reads. |
| dout | output | 4 | Registered data output. |

## Verification
The hardest case to reach is an idle cycle (`rw`=1, `en`=0) that carries a live address and fresh data. Such a cycle must leave both the stored word and the output untouched, and the only way to see a wrong store is a later read of that exact word.

The stimulus therefore places idle cycles with changing data directly after writes and reads. It then reads back the words those idle cycles pointed at. A long pseudo-random mix of the three operations follows, compared each cycle against a behavioural array model.

// File: rtl/nram_pkg.sv
// Package: shared operation type for the nibble RAM.
// Assumes: the select and enable inputs are the only inputs that choose the operation.
package nram_pkg;

    // The one operation carried out at a clock edge.
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_HOLD  = 2'd1,
        OP_WRITE = 2'd2
    } nram_op_e;

    // Turns the select and enable inputs into an operation; the enable only matters when writing.
    function automatic nram_op_e classify_op(input logic rw, input logic en);
        if (!rw)
            return OP_READ;
        else if (en)
            return OP_WRITE;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/nram_decode.sv
// Module: nram_decode
// Drives one load strobe for each word. A strobe is high only for the addressed word,
// and only during a write.
// Assumes: wr_go is already qualified by both the select and the enable.
module nram_decode #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] addr,
    output logic [DEPTH-1:0]  load
);

    // One address comparator for each word.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_dec
        always_comb load[gi] = wr_go && (addr == ADDR_W'(gi));
    end

    // R7
    // At most one word is loaded at any edge.
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load));

endmodule

// File: rtl/nram_cell.sv
// Module: nram_cell
// One storage word. A multiplexer in the data path chooses between keeping the
// current value and taking new data, so the clock is never gated.
// Assumes: load is a single-cycle decoded strobe from the address decoder.
module nram_cell #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] q_next;

    // Hold/load selection ahead of the flip-flops.
    always_comb q_next = load ? wdata : q;

    // Word register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= q_next;
    end

    // R3
    // A word that is not loaded keeps its value.
    cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (q == $past(q)));

    // R2
    // A loaded word holds the write data after the edge.
    cell_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(wdata)));

endmodule

// File: rtl/nram_outsel.sv
// Module: nram_outsel
// Output register. On a read it takes the addressed word. On a write it takes the
// incoming data, so written data passes straight through. Otherwise it holds.
// Assumes: words is the concatenation of all words, with word 0 in the low bits.
module nram_outsel
    import nram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  nram_op_e                op,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       din,
    input  logic [DEPTH*DATA_W-1:0] words,
    output logic [DATA_W-1:0]       dout
);

    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] dout_next;

    // Read multiplexer: picks the addressed word out of the concatenated bus.
    always_comb rd_word = words[addr*DATA_W +: DATA_W];

    // Chooses the next output value from the operation.
    always_comb begin
        unique case (op)
            OP_READ:  dout_next = rd_word;
            OP_WRITE: dout_next = din;
            default:  dout_next = dout;
        endcase
    end

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else
            dout <= dout_next;
    end

    // R3
    out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(dout));

    // R5
    out_wthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> (dout == $past(din)));

    // R6
    out_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dout == '0));

endmodule

// File: rtl/nram_core.sv
// Module: nram_core
// Top level of the sixteen-word nibble RAM. It classifies the operation, decodes
// the write strobes, instantiates the words, and registers the output.
// Assumes: a single clock and a synchronous active-low reset.
module nram_core
    import nram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              rw,
    input  logic              en,
    output logic [DATA_W-1:0] dout
);

    nram_op_e                op;
    logic [DEPTH-1:0]        load;
    logic [DEPTH*DATA_W-1:0] words;

    // Operation for this edge.
    always_comb op = classify_op(rw, en);

    nram_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_go (op == OP_WRITE),
        .addr  (addr),
        .load  (load)
    );

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        nram_cell #(.DATA_W(DATA_W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load[gi]),
            .wdata (din),
            .q     (words[gi*DATA_W +: DATA_W])
        );
    end

    nram_outsel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .addr  (addr),
        .din   (din),
        .words (words),
        .dout  (dout)
    );

    // R4
    // A read leaves every word unchanged, whatever the enable is.
    read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |=> (words == $past(words)));

    // R6
    words_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (words == '0));

endmodule

// File: tb/nram_core_test.sv
// Bench for nram_core. A behavioural array model is updated at every rising edge
// and compared with dout at every falling edge.
module nram_core_test;

    localparam int PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [3:0] addr = '0;
    logic [3:0] din = '0;
    logic       rw = 0;
    logic       en = 0;
    logic [3:0] dout;

    int         model [16];
    int         exp_out = 0;
    int         total = 0;
    int         bad = 0;
    int         seed = 12345;

    nram_core uut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .din   (din),
        .rw    (rw),
        .en    (en),
        .dout  (dout)
    );

    always #(PERIOD/2) clk = ~clk;

    // Compares dout with the model's expected value.
    task automatic check_out(input string req);
        total++;
        if (dout !== 4'(exp_out)) begin
            bad++;
            $display("FAIL %s: dout actual=%h expected=%h at %0t", req, dout, exp_out, $time);
        end
    endtask

    // Drives one operation from a falling edge, updates the model at the rising
    // edge, then checks dout at the next falling edge.
    task automatic step(input logic r, input logic e, input int a, input int d, input string req);
        rw = r; en = e; addr = 4'(a); din = 4'(d);
        @(posedge clk);
        if (!rst_n) begin
            foreach (model[k]) model[k] = 0;
            exp_out = 0;
        end else if (!r) begin
            exp_out = model[a];
        end else if (e) begin
            model[a] = d;
            exp_out = d;
        end
        @(negedge clk);
        check_out(req);
    endtask

    // Returns the next value of a simple linear congruential generator.
    function automatic int next_rand();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return seed >>> 8;
    endfunction

    initial begin : watchdog
        #(PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        foreach (model[k]) model[k] = 0;
        @(negedge clk);
        // R6: dout is cleared while reset is held.
        step(1, 1, 5, 9, "R6");
        step(0, 0, 5, 0, "R6");
        rst_n = 1;
        // R1, R2, R5: write a distinct pattern to every word.
        for (int a = 0; a < 16; a++) step(1, 1, a, a ^ 5, "R5");
        // R1, R4: read every word back, with en low and then en high.
        for (int a = 0; a < 16; a++) step(0, a[0], a, 15 - a, "R4");
        for (int a = 15; a >= 0; a--) step(0, 1, a, 0, "R4");
        // R3: idle cycles with live address and data, then read the words they pointed at.
        step(0, 0, 7, 0, "R4");
        step(1, 0, 7, 15, "R3");
        step(1, 0, 2, 0, "R3");
        step(0, 0, 7, 0, "R3");
        step(0, 1, 2, 0, "R3");
        // R7: write 1000 at address 0011 and check the neighbouring words.
        step(1, 1, 3, 8, "R7");
        step(0, 0, 2, 0, "R7");
        step(0, 0, 4, 0, "R7");
        step(0, 0, 3, 0, "R7");
        // R5: back-to-back writes to the same word, then idle.
        step(1, 1, 3, 1, "R5");
        step(1, 1, 3, 14, "R5");
        step(1, 0, 3, 6, "R3");
        step(0, 0, 3, 0, "R2");
        // Mixed pseudo-random traffic.
        for (int i = 0; i < 400; i++) begin
            int v;
            v = next_rand();
            step(v[0] | v[1], v[2], (v >> 4) & 15, (v >> 8) & 15, "R2");
        end
        // R6: reset in mid-run, then every word must read back as zero.
        rst_n = 0;
        step(1, 1, 9, 12, "R6");
        rst_n = 1;
        for (int a = 0; a < 16; a++) step(0, 0, a, 0, "R6");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule